// File: doc/BRIEF.md
# Bus Handover Arbiter (Processor Side)

This block sits beside a bus-master processor and manages the handover of its address, data and control buses to one external master. The external master uses three active-low wires. It pulls a request line low to ask for the bus. The block answers with an active-low grant. The master then confirms the takeover on a grant-acknowledge line. The block turns the processor's own bus drivers off only after that confirmation arrives. It turns them back on when the acknowledge is withdrawn.

Every input is treated as asynchronous and passes through a synchronizer chain before any decision uses it. The block also watches the local address strobe and the data acknowledge. A takeover confirmation is honoured only when the current bus cycle has ended, so ownership never changes in the middle of a transfer. While a grant is outstanding, the block withholds permission for the processor to start a new cycle. A request that is withdrawn before any confirmation cancels the grant.

Top module: `bus_handover_arb`

## Requirements
- R1: During and just after reset, outputs are `bus_grant_n_o`=1, `drv_en_o`=1, `owns_bus_o`=1 and `cycle_permit_o`=1.
- R2: A low level on `bus_req_n_i` while the processor owns the bus drives `bus_grant_n_o` low and `cycle_permit_o` low. Drivers stay enabled while only the grant is out.
- R3: When `grant_ack_n_i` is low during a grant and the bus is idle, the block releases the bus. The bus is idle when `addr_strobe_n_i`=1 and `data_ack_n_i`=1. On release, `drv_en_o`=0, `owns_bus_o`=0 and `bus_grant_n_o` returns to 1.
- R4: While `addr_strobe_n_i` is low, a low `grant_ack_n_i` does not release the bus. The grant and the drivers stay as they are until the strobe goes high.
- R5: While `data_ack_n_i` is low, a low `grant_ack_n_i` does not release the bus.
- R6: If `bus_req_n_i` returns high before any acknowledge, the grant is withdrawn. `bus_grant_n_o` goes to 1 and `cycle_permit_o` goes to 1, and the processor keeps the bus.
- R7: While released and `grant_ack_n_i` stays low, changes on the request, strobe and data acknowledge inputs have no effect. The drivers stay off.
- R8: When `grant_ack_n_i` returns high after a release, the processor retakes the bus. `drv_en_o`, `owns_bus_o` and `cycle_permit_o` all go to 1.
- R9: A low `grant_ack_n_i` while no grant is outstanding is ignored, and the processor keeps the bus.
- R10: An output responds exactly SYNC_STAGES+1 rising clock edges after an input change. The default is 3 edges. No output changes earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req_n_i | input | 1 | External master's bus request, active low, asynchronous |
| grant_ack_n_i | input | 1 | External master's takeover confirmation, active low, asynchronous |
| addr_strobe_n_i | input | 1 | Local address strobe, active low, asynchronous |
| data_ack_n_i | input | 1 | Data transfer acknowledge, active low, asynchronous |
| bus_grant_n_o | output | 1 | Bus grant to the external master, active low |
| drv_en_o | output | 1 | Output enable for the processor's bus drivers |
| owns_bus_o | output | 1 | High while the processor is bus master |
| cycle_permit_o | output | 1 | High when the processor may start a new bus cycle |

## Verification
If the handover state machine is wrong, the fault appears on the grant or driver-enable pins. It shows up exactly three edges after the stimulating input change: as a missing grant, as drivers switched off in the middle of a strobe, or as drivers that stay off after the acknowledge has been withdrawn. A synchronizer of the wrong depth moves every response earlier or later by whole cycles. The bench therefore samples the outputs both one edge before and at the expected edge. A state that ignores bus idleness shows up only when the acknowledge arrives while the strobe or the data acknowledge is still low, so those input patterns are driven on purpose.

// File: rtl/bha_pkg.sv
package bha_pkg;
   typedef enum logic [1:0] {
      ST_OWN      = 2'd0,
      ST_GRANT    = 2'd1,
      ST_RELEASED = 2'd2
   } bha_state_e;

   localparam int unsigned BHA_MIN_SYNC = 2;
   localparam int unsigned BHA_MAX_SYNC = 8;
endpackage

// File: rtl/bha_sync.sv
module bha_sync #(
   parameter int unsigned WIDTH     = 4,
   parameter int unsigned STAGES    = 2,
   parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   import bha_pkg::*;

   generate
      if (STAGES < BHA_MIN_SYNC || STAGES > BHA_MAX_SYNC) begin : g_bad_depth
         $error("bha_sync: STAGES out of range");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("bha_sync: WIDTH must be at least 1");
      end
   endgenerate

   genvar b;
   generate
      for (b = 0; b < WIDTH; b++) begin : g_bit
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RESET_VAL[b]}};
            else        chain <= {chain[STAGES-2:0], d_i[b]};
         end
         assign q_o[b] = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/bha_idle_gate.sv
module bha_idle_gate #(
   parameter bit WATCH_IDLE = 1'b1
) (
   input  logic strobe_s_n,
   input  logic dack_s_n,
   output logic idle_o
);
   generate
      if (WATCH_IDLE) begin : g_watch
         assign idle_o = strobe_s_n & dack_s_n;
      end else begin : g_blind
         logic unused_in;
         assign unused_in = strobe_s_n ^ dack_s_n;
         assign idle_o    = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/bha_fsm.sv
module bha_fsm (
   input  logic clk,
   input  logic rst_n,
   input  logic req_s_n,
   input  logic ack_s_n,
   input  logic idle_i,
   output logic grant_n_o,
   output logic drv_en_o,
   output logic owns_o,
   output logic permit_o
);
   import bha_pkg::*;

   bha_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_OWN: begin
            if (!req_s_n) state_d = ST_GRANT;
         end
         ST_GRANT: begin
            if (!ack_s_n && idle_i)     state_d = ST_RELEASED;
            else if (req_s_n && ack_s_n) state_d = ST_OWN;
         end
         ST_RELEASED: begin
            if (ack_s_n) state_d = ST_OWN;
         end
         default: state_d = ST_OWN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_OWN;
      else        state_q <= state_d;
   end

   assign grant_n_o = (state_q != ST_GRANT);
   assign drv_en_o  = (state_q != ST_RELEASED);
   assign owns_o    = (state_q != ST_RELEASED);
   assign permit_o  = (state_q == ST_OWN);

   // R2
   grant_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(grant_n_o) |-> !$past(req_s_n));
   // R3
   release_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(drv_en_o) |-> ($past(idle_i) && !$past(ack_s_n)));
   // R6
   withdraw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!grant_n_o && req_s_n && ack_s_n) |=> (grant_n_o && owns_o));
   // R7
   hold_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!drv_en_o && !ack_s_n) |=> !drv_en_o);
   // R8
   retake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drv_en_o) |-> $past(ack_s_n));
   // R9
   ack_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (permit_o && req_s_n) |=> (owns_o && grant_n_o));
endmodule

// File: rtl/bus_handover_arb.sv
module bus_handover_arb #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          WATCH_IDLE  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_req_n_i,
   input  logic grant_ack_n_i,
   input  logic addr_strobe_n_i,
   input  logic data_ack_n_i,
   output logic bus_grant_n_o,
   output logic drv_en_o,
   output logic owns_bus_o,
   output logic cycle_permit_o
);
   localparam int unsigned N_ASYNC = 4;
   localparam int unsigned I_REQ = 0;
   localparam int unsigned I_ACK = 1;
   localparam int unsigned I_STB = 2;
   localparam int unsigned I_DAK = 3;

   logic [N_ASYNC-1:0] raw_n, sync_n;
   logic idle;

   assign raw_n[I_REQ] = bus_req_n_i;
   assign raw_n[I_ACK] = grant_ack_n_i;
   assign raw_n[I_STB] = addr_strobe_n_i;
   assign raw_n[I_DAK] = data_ack_n_i;

   bha_sync #(
      .WIDTH(N_ASYNC), .STAGES(SYNC_STAGES), .RESET_VAL({N_ASYNC{1'b1}})
   ) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(raw_n), .q_o(sync_n)
   );

   bha_idle_gate #(.WATCH_IDLE(WATCH_IDLE)) u_idle (
      .strobe_s_n(sync_n[I_STB]), .dack_s_n(sync_n[I_DAK]), .idle_o(idle)
   );

   bha_fsm u_fsm (
      .clk(clk), .rst_n(rst_n),
      .req_s_n(sync_n[I_REQ]), .ack_s_n(sync_n[I_ACK]), .idle_i(idle),
      .grant_n_o(bus_grant_n_o), .drv_en_o(drv_en_o),
      .owns_o(owns_bus_o), .permit_o(cycle_permit_o)
   );

   generate
      if (WATCH_IDLE) begin : g_idle_chk
         // R4
         no_release_in_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(drv_en_o) |-> $past(sync_n[I_STB]));
         // R5
         no_release_in_dack_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(drv_en_o) |-> $past(sync_n[I_DAK]));
      end
   endgenerate

   // R2
   no_cycle_while_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_grant_n_o |-> !cycle_permit_o);
endmodule

// File: tb/bus_handover_arb_test.sv
module bus_handover_arb_test;
   localparam int CLK_PERIOD = 10;
   localparam int LAT = 3;
   localparam int NVEC = 12;
   // {req_n, ack_n, strobe_n, dack_n, exp grant_n, drv_en, owns, permit, req number}
   localparam logic [11:0] VEC [NVEC] = '{
      12'b1111_1111_0001, // R1 idle
      12'b0111_0110_0010, // R2 grant issued
      12'b0001_0110_0100, // R4 ack during strobe: hold
      12'b0010_0110_0101, // R5 ack during data ack: hold
      12'b0011_1000_0011, // R3 idle: release
      12'b1011_1000_0111, // R7 request dropped, still released
      12'b0000_1000_0111, // R7 busy lines while released
      12'b1111_1111_1000, // R8 retake
      12'b0111_0110_0010, // R2 grant again
      12'b1111_1111_0110, // R6 withdrawn request
      12'b1011_1111_1001, // R9 stray ack ignored
      12'b1111_1111_1001  // R9 back to idle
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_n = 1'b1, ack_n = 1'b1, stb_n = 1'b1, dak_n = 1'b1;
   logic grant_n, drv_en, owns, permit;
   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bus_handover_arb uut (
      .clk(clk), .rst_n(rst_n),
      .bus_req_n_i(req_n), .grant_ack_n_i(ack_n),
      .addr_strobe_n_i(stb_n), .data_ack_n_i(dak_n),
      .bus_grant_n_o(grant_n), .drv_en_o(drv_en),
      .owns_bus_o(owns), .cycle_permit_o(permit)
   );

   task automatic check(input int rq, input logic [3:0] exp);
      logic [3:0] act;
      act = {grant_n, drv_en, owns, permit};
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL R%0d: {grant_n,drv_en,owns,permit} actual=%b expected=%b", rq, act, exp);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(1, 4'b1111); // R1 during reset
      rst_n = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check(1, 4'b1111); // R1 after reset

      for (int i = 0; i < NVEC; i++) begin
         {req_n, ack_n, stb_n, dak_n} = VEC[i][11:8];
         repeat (LAT) @(posedge clk);
         @(negedge clk);
         check(int'(VEC[i][3:0]), VEC[i][7:4]);
      end

      // R10 latency: not early, then exact
      req_n = 1'b0;
      repeat (LAT - 1) @(posedge clk);
      @(negedge clk);
      check(10, 4'b1111);
      @(posedge clk);
      @(negedge clk);
      check(10, 4'b0110);

      // R1 reset while granted
      rst_n = 1'b0;
      #1;
      check(1, 4'b1111);
      req_n = 1'b1;
      @(negedge clk);
      rst_n = 1'b1;
      repeat (LAT + 1) @(posedge clk);
      @(negedge clk);
      check(1, 4'b1111);

      // R8 latency on retake: release then drop ack
      req_n = 1'b0;
      repeat (LAT) @(posedge clk);
      @(negedge clk);
      ack_n = 1'b0;
      repeat (LAT) @(posedge clk);
      @(negedge clk);
      check(3, 4'b1000);
      ack_n = 1'b1;
      req_n = 1'b1;
      repeat (LAT - 1) @(posedge clk);
      @(negedge clk);
      check(10, 4'b1000);
      @(posedge clk);
      @(negedge clk);
      check(8, 4'b1111);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule